// File: doc/BRIEF.md
# Sequential Non-Restoring Divide Unit

This block is the divide path of an 18-bit accumulator machine. A 36-bit dividend is held across two registers, the accumulator (upper half) and the multiplier-quotient register (lower half). The block divides it by an 18-bit divisor over several clock cycles. The quotient replaces the lower half and the remainder replaces the upper half. The divider works one quotient bit per cycle. Each cycle it samples the sign of the partial remainder, then adds or subtracts the divisor, then shifts left by one. Both subtraction and addition are done in two's complement.

A step count passed with each operation sets the precision. The control loads the count as its two's complement and counts up until it reaches zero. A full-precision divide uses 19 steps; a smaller count gives a shorter divide with fewer quotient bits. The operation starts with a trial subtraction of the divisor from the upper half. That first step already shows whether the quotient will fit. If it will not, the overflow path ends the operation early and raises the link flag.

An unsigned mode and a ones'-complement signed mode are provided. In signed mode the divisor arrives as a magnitude and its sign arrives on the link input. A negative dividend is complemented before the arithmetic phase, and quotient and remainder are complemented after it as the signs require. A single-cycle start strobe samples the operands, mode and step count. A single-cycle done strobe marks the results, which then stay stable until the next operation completes.

Top module: `nrdiv_unit`

## Requirements
- R1: With unsigned mode, step count 19 and no overflow, the dividend D = {acIn, mqIn} and divisor d give mqOut = floor(D / d) and acOut = D mod d.
- R2: With step count S (1 to 19), the divided value is acIn followed by the S-1 most significant bits of mqIn. The quotient appears in the low S-1 bits of mqOut and the whole remainder appears in acOut. The upper 19-S bits of mqOut are undefined.
- R3: In unsigned mode, an operation overflows when acIn >= divisorIn, a zero divisor included. On overflow linkOut is 1 and done rises on the 5th rising edge after the edge that sampled start. acOut and mqOut are then undefined.
- R4: In unsigned mode (linkIn held at 0), a divide that does not overflow returns linkOut = 0.
- R5: In signed mode the dividend is a 36-bit ones'-complement value, negative when acIn bit 17 is set, and its magnitude is the bitwise complement of {acIn, mqIn}. divisorIn is a magnitude and linkIn is its sign (1 = negative). The magnitudes are divided as in R1/R2. The 18-bit quotient is complemented when the two signs differ. The remainder is complemented when the dividend is negative. linkOut is 0.
- R6: In signed mode, an operation overflows when {dividend-magnitude upper half, dividend-magnitude bit 17} >= divisorIn. The link and timing are the same as in R3.
- R7: done is a one-cycle pulse. A divide that does not overflow raises done on rising edge S+1 after the edge that sampled start.
- R8: acOut, mqOut and linkOut change only on the edge that raises done, and hold their values at all other times.
- R9: After reset, done, acOut, mqOut and linkOut are all 0.

Bit 17 is the most significant bit of every 18-bit port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that samples the operands and begins a divide |
| signedMode | input | 1 | 1 selects ones'-complement signed divide, 0 selects unsigned |
| stepField | input | 6 | Number of steps, 1 to 19 (19 = full precision) |
| acIn | input | 18 | Upper half of the dividend |
| mqIn | input | 18 | Lower half of the dividend |
| divisorIn | input | 18 | Divisor (a magnitude in signed mode) |
| linkIn | input | 1 | Divisor sign in signed mode; must be 0 in unsigned mode |
| done | output | 1 | One-cycle strobe marking valid results |
| acOut | output | 18 | Remainder |
| mqOut | output | 18 | Quotient |
| linkOut | output | 1 | Overflow flag |

## Verification
The assertions assume that start arrives only while the unit is idle and that the step count lies between 1 and 19. They also assume linkIn is 0 in unsigned mode and that a signed operand is well formed: divisor bit 17 clear, and acIn bits 17 and 16 equal (the doubled sign). The bench builds every operand inside these limits. It waits for done before each new start. It chooses the signed dividend magnitude from a value below 2^17 and then applies the sign by complementing. Overflow cases are made on purpose by choosing the upper half at or above the divisor.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  localparam int unsigned DIV_DATA_W  = 18;
  localparam int unsigned DIV_STEP_W  = 6;
  localparam int unsigned DIV_OVF_LAT = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands
    logic prep;    // sign handling and trial subtraction
    logic step;    // one non-restoring iteration
    logic fix;     // remainder correction and result write
    logic ovfEnd;  // overflow result write
  } divCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_STEP,
    ST_FIX,
    ST_OVF
  } divState_t;
endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int unsigned STEP_W  = DIV_STEP_W,
  parameter int unsigned OVF_LAT = DIV_OVF_LAT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [STEP_W-1:0] stepField,
  input  logic              firstOvf,
  output divCtrl_t          ctl,
  output logic              done
);
  // overflow wait: PREP plus OVF_LAT-1 further edges
  localparam logic [STEP_W-1:0] OVF_LOAD = {STEP_W{1'b0}} - STEP_W'(OVF_LAT - 1);

  divState_t         state;
  logic [STEP_W-1:0] stepCtr;
  logic [STEP_W-1:0] ctrInc;
  logic              ctrWrap;
  logic              doneR;

  assign ctrInc  = stepCtr + 1'b1;
  assign ctrWrap = (ctrInc == '0);
  assign done    = doneR;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: ctl.load   = start;
      ST_PREP: ctl.prep   = 1'b1;
      ST_STEP: ctl.step   = 1'b1;
      ST_FIX:  ctl.fix    = 1'b1;
      ST_OVF:  ctl.ovfEnd = ctrWrap;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCtr <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            stepCtr <= {STEP_W{1'b0}} - stepField;
            state   <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (firstOvf) begin
            stepCtr <= OVF_LOAD;
            state   <= ST_OVF;
          end else begin
            stepCtr <= ctrInc;
            state   <= ctrWrap ? ST_FIX : ST_STEP;
          end
        end
        ST_STEP: begin
          stepCtr <= ctrInc;
          if (ctrWrap) state <= ST_FIX;
        end
        ST_FIX: begin
          doneR <= 1'b1;
          state <= ST_IDLE;
        end
        ST_OVF: begin
          stepCtr <= ctrInc;
          if (ctrWrap) begin
            doneR <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrdiv_dpath.sv
module nrdiv_dpath
  import nrdiv_pkg::*;
#(
  parameter int unsigned DATA_W = DIV_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtrl_t          ctl,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] acIn,
  input  logic [DATA_W-1:0] mqIn,
  input  logic [DATA_W-1:0] divisorIn,
  input  logic              linkIn,
  output logic              firstOvf,
  output logic [DATA_W-1:0] acOut,
  output logic [DATA_W-1:0] mqOut,
  output logic              linkOut
);
  // partial remainder lies in [-2d, 2d): two extra bits
  localparam int unsigned RW = DATA_W + 2;

  logic [DATA_W-1:0] hiR, mqR, dvsR;
  logic              modeR, divSignR, dSignR, qSignR;
  logic [RW-1:0]     remR;
  logic [DATA_W-1:0] acQ, mqQ;
  logic              linkQ;

  logic              negDiv;
  logic [DATA_W-1:0] hiMag, loMag;
  logic [DATA_W:0]   cmpLhs;
  logic [RW-1:0]     dvsExt, firstDiff, shifted, stepRes;
  logic [DATA_W-1:0] remLow;

  always_comb begin
    negDiv    = modeR & hiR[DATA_W-1];
    hiMag     = negDiv ? ~hiR : hiR;
    loMag     = negDiv ? ~mqR : mqR;
    dvsExt    = {2'b00, dvsR};
    // signed quotient must fit DATA_W-1 bits, so compare one bit lower
    cmpLhs    = modeR ? {hiMag, loMag[DATA_W-1]} : {1'b0, hiMag};
    firstOvf  = (cmpLhs >= {1'b0, dvsR});
    firstDiff = {2'b00, hiMag} - dvsExt;
    shifted   = {remR[RW-2:0], mqR[DATA_W-1]};
    stepRes   = remR[RW-1] ? (shifted + dvsExt) : (shifted - dvsExt);
    remLow    = remR[RW-1] ? (remR[DATA_W-1:0] + dvsR) : remR[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiR      <= '0;
      mqR      <= '0;
      dvsR     <= '0;
      modeR    <= 1'b0;
      divSignR <= 1'b0;
      dSignR   <= 1'b0;
      qSignR   <= 1'b0;
      remR     <= '0;
      acQ      <= '0;
      mqQ      <= '0;
      linkQ    <= 1'b0;
    end else begin
      if (ctl.load) begin
        hiR      <= acIn;
        mqR      <= mqIn;
        dvsR     <= divisorIn;
        modeR    <= signedMode;
        divSignR <= signedMode & linkIn;
      end
      if (ctl.prep) begin
        remR   <= firstDiff;
        mqR    <= loMag;
        dSignR <= negDiv;
        qSignR <= negDiv ^ divSignR;
      end
      if (ctl.step) begin
        remR <= stepRes;
        mqR  <= {mqR[DATA_W-2:0], ~stepRes[RW-1]};
      end
      if (ctl.fix) begin
        acQ   <= dSignR ? ~remLow : remLow;
        mqQ   <= qSignR ? ~mqR : mqR;
        linkQ <= 1'b0;
      end
      if (ctl.ovfEnd) begin
        linkQ <= 1'b1;
      end
    end
  end

  assign acOut   = acQ;
  assign mqOut   = mqQ;
  assign linkOut = linkQ;
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit
  import nrdiv_pkg::*;
#(
  parameter int unsigned DATA_W  = DIV_DATA_W,
  parameter int unsigned STEP_W  = DIV_STEP_W,
  parameter int unsigned OVF_LAT = DIV_OVF_LAT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              signedMode,
  input  logic [STEP_W-1:0] stepField,
  input  logic [DATA_W-1:0] acIn,
  input  logic [DATA_W-1:0] mqIn,
  input  logic [DATA_W-1:0] divisorIn,
  input  logic              linkIn,
  output logic              done,
  output logic [DATA_W-1:0] acOut,
  output logic [DATA_W-1:0] mqOut,
  output logic              linkOut
);
  divCtrl_t ctl;
  logic     firstOvf;

  nrdiv_ctrl #(.STEP_W(STEP_W), .OVF_LAT(OVF_LAT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stepField (stepField),
    .firstOvf  (firstOvf),
    .ctl       (ctl),
    .done      (done)
  );

  nrdiv_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .signedMode (signedMode),
    .acIn       (acIn),
    .mqIn       (mqIn),
    .divisorIn  (divisorIn),
    .linkIn     (linkIn),
    .firstOvf   (firstOvf),
    .acOut      (acOut),
    .mqOut      (mqOut),
    .linkOut    (linkOut)
  );
endmodule

// File: rtl/nrdiv_unit_chk.sv
module nrdiv_unit_chk #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned STEP_W  = 6,
  parameter int unsigned OVF_LAT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              signedMode,
  input logic [STEP_W-1:0] stepField,
  input logic [DATA_W-1:0] acIn,
  input logic [DATA_W-1:0] mqIn,
  input logic [DATA_W-1:0] divisorIn,
  input logic              linkIn,
  input logic              done,
  input logic [DATA_W-1:0] acOut,
  input logic [DATA_W-1:0] mqOut,
  input logic              linkOut
);
  localparam int unsigned FULL = DATA_W + 1;
  localparam int unsigned DW2  = 2 * DATA_W;

  logic              busy;
  logic [7:0]        cyc;
  logic [STEP_W-1:0] stepCap;
  logic              modeCap;
  logic [DATA_W-1:0] divCap;
  logic [DW2-1:0]    dividendCap;
  logic [DW2-1:0]    recon;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      cyc         <= '0;
      stepCap     <= '0;
      modeCap     <= 1'b0;
      divCap      <= '0;
      dividendCap <= '0;
    end else begin
      if (start && !busy) begin
        busy        <= 1'b1;
        cyc         <= '0;
        stepCap     <= stepField;
        modeCap     <= signedMode;
        divCap      <= divisorIn;
        dividendCap <= {acIn, mqIn};
      end else if (busy) begin
        cyc <= cyc + 8'd1;
        if (done) busy <= 1'b0;
      end
    end
  end

  assign recon = DW2'(mqOut) * DW2'(divCap) + DW2'(acOut);

  // input limits the block relies on
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (stepField >= STEP_W'(1) && stepField <= STEP_W'(FULL)));
  assert_link_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !signedMode) |-> !linkIn);
  assert_signed_form_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && signedMode) |-> (!divisorIn[DATA_W-1] && acIn[DATA_W-1] == acIn[DATA_W-2]));

  // behaviour
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !linkOut) |-> (cyc == 8'(stepCap) + 8'd1));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_ovf_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && linkOut) |-> (cyc == 8'(OVF_LAT)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({acOut, mqOut, linkOut}));
  assert_unsigned_ovf_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeCap && dividendCap[DW2-1:DATA_W] >= divCap) |-> linkOut);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeCap && dividendCap[DW2-1:DATA_W] < divCap) |-> !linkOut);
  assert_exact_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !linkOut && !modeCap && stepCap == STEP_W'(FULL))
      |-> (recon == dividendCap && acOut < divCap));
endmodule

bind nrdiv_unit nrdiv_unit_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W), .OVF_LAT(OVF_LAT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .signedMode (signedMode),
  .stepField  (stepField),
  .acIn       (acIn),
  .mqIn       (mqIn),
  .divisorIn  (divisorIn),
  .linkIn     (linkIn),
  .done       (done),
  .acOut      (acOut),
  .mqOut      (mqOut),
  .linkOut    (linkOut)
);

// File: tb/nrdiv_unit_tb.sv
module nrdiv_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [5:0]  stepField = 6'd19;
  logic [17:0] acIn = '0, mqIn = '0, divisorIn = '0;
  logic        linkIn = 1'b0;
  logic        done;
  logic [17:0] acOut, mqOut;
  logic        linkOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  nrdiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .stepField(stepField), .acIn(acIn), .mqIn(mqIn), .divisorIn(divisorIn),
    .linkIn(linkIn), .done(done), .acOut(acOut), .mqOut(mqOut), .linkOut(linkOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected results from the requirement text
  task automatic model(input bit sm, input int s, input logic [17:0] ac, mq, d,
                       input bit lk, output bit ovf, output logic [17:0] q, r);
    logic [35:0] m, eff, qq, rr;
    bit neg;
    neg = sm && ac[17];
    m = neg ? ~{ac, mq} : {ac, mq};
    if (sm) ovf = ({1'b0, m[35:17]} >= {2'b00, d});
    else    ovf = (m[35:18] >= d);
    q = '0;
    r = '0;
    if (!ovf) begin
      eff = m >> (19 - s);
      qq = eff / {18'd0, d};
      rr = eff % {18'd0, d};
      q = qq[17:0];
      r = rr[17:0];
      if (sm && (neg ^ lk)) q = ~q;
      if (neg) r = ~r;
    end
  endtask

  task automatic runOne(input bit sm, input int s, input logic [17:0] ac, mq, d,
                        input bit lk, input string req);
    bit ovf;
    logic [17:0] q, r, mask, holdA, holdQ;
    int lat;
    int expLat;
    model(sm, s, ac, mq, d, lk, ovf, q, r);
    mask = (s >= 19) ? 18'h3FFFF : 18'((1 << (s - 1)) - 1);
    @(negedge clk);
    start = 1'b1; signedMode = sm; stepField = 6'(s);
    acIn = ac; mqIn = mq; divisorIn = d; linkIn = lk;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    expLat = ovf ? 5 : s + 1;
    chk(lat == expLat, ovf ? "R3/R6" : "R7", {req, " latency"}, 64'(lat), 64'(expLat));
    chk(linkOut == ovf, ovf ? "R3/R6" : "R4", {req, " link"}, 64'(linkOut), 64'(ovf));
    if (!ovf) begin
      chk((mqOut & mask) == (q & mask), req, "quotient", 64'(mqOut & mask), 64'(q & mask));
      chk(acOut == r, req, "remainder", 64'(acOut), 64'(r));
    end
    holdA = acOut;
    holdQ = mqOut;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done pulse width", 64'(done), 64'd0);
    chk(acOut == holdA && mqOut == holdQ, "R8", "outputs hold",
        {14'd0, acOut, 14'd0, mqOut}, {14'd0, holdA, 14'd0, holdQ});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [17:0] d, hi, lo, x;
    bit neg;
    int s;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(done == 0 && acOut == 0 && mqOut == 0 && linkOut == 0, "R9", "reset outputs",
        {28'd0, done, acOut, linkOut}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed
    runOne(0, 19, 18'd0, 18'd12, 18'd5, 0, "R1 12/5");
    runOne(0, 19, 18'h3FFFE, 18'h3FFFF, 18'h3FFFF, 0, "R1 max quotient");
    runOne(0, 19, 18'd100, 18'd7, 18'd101, 0, "R4 hi just below divisor");
    runOne(0, 19, 18'd101, 18'd7, 18'd101, 0, "R3 hi equals divisor");
    runOne(0, 19, 18'd0, 18'd55, 18'd0, 0, "R3 zero divisor");
    runOne(0, 1, 18'd9, 18'h2AAAA, 18'd20, 0, "R2 one step");
    runOne(0, 5, 18'd3, 18'h3C000, 18'd7, 0, "R2 five steps");
    runOne(1, 19, 18'd0, 18'd12, 18'd5, 0, "R5 pos/pos");
    runOne(1, 19, 18'd0, 18'd12, 18'd5, 1, "R5 pos/neg");
    runOne(1, 19, 18'h3FFFF, ~18'd12, 18'd5, 0, "R5 neg/pos");
    runOne(1, 19, 18'h3FFFF, ~18'd12, 18'd5, 1, "R5 neg/neg");
    runOne(1, 19, 18'h3FFFF, 18'h3FFFF, 18'd9, 0, "R5 negative zero");
    runOne(1, 19, 18'd50, 18'h20000, 18'd101, 0, "R6 boundary equal");
    runOne(1, 19, 18'd50, 18'h1FFFF, 18'd101, 0, "R6 boundary below");
    runOne(1, 7, 18'h3FFF0, 18'h12345, 18'd40, 1, "R2 signed reduced");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      s = ($urandom % 3 == 0) ? 1 + int'($urandom % 19) : 19;
      if (i % 2 == 0) begin
        d = 18'($urandom);
        if (d == 0) d = 18'd1;
        if (i % 10 == 0) hi = d + 18'($urandom % (32'd262144 - 32'(d)));
        else             hi = 18'($urandom % 32'(d));
        lo = 18'($urandom);
        runOne(0, s, hi, lo, d, 0, "R1 random unsigned");
      end else begin
        d = 18'(1 + $urandom % 131071);
        if (i % 10 == 1) x = d + 18'($urandom % (32'd131072 - 32'(d)));
        else             x = 18'($urandom % 32'(d));
        hi = x >> 1;
        lo = {x[0], 17'($urandom)};
        neg = $urandom % 2;
        runOne(1, s, neg ? ~hi : hi, neg ? ~lo : lo, d, bit'($urandom % 2),
               "R5 random signed");
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule